// File: doc/BRIEF.md
# Write-update snooping data cache

This block is a small direct-mapped data cache for one processor on a shared bus. Each line holds one word and has one of four states: empty, clean and private, clean and possibly held elsewhere, or modified and private. Coherence is kept by broadcasting new data rather than killing other copies. Bus traffic never sends a line back to the empty state. Only a replacement empties a line.

On the processor side a request is held until `cpu_rdy` is seen high at a clock edge. Hits finish in the cycle they are presented. Misses, write-backs and update broadcasts hold `cpu_rdy` low until the bus acknowledges the last transaction. On the bus side the cache issues reads, updates and write-backs, and samples the wired-OR sharing line in the acknowledge cycle. It also watches the transactions of the other caches. When one of them hits a line it holds, the cache raises the sharing line, copies in broadcast data and supplies modified data to memory.

Top module: `wupd_cache`

## Requirements
- R1: After reset every line is empty. `bus_req` and `cpu_rdy` are low, and no snooped transaction raises `snp_hit`.
- R2: A read miss issues a bus read (`bus_cmd` 0) at the requested address. The line is filled from `bus_rdata` and returned in the acknowledge cycle. It is installed clean-private if `bus_shared` was low and clean-shared if it was high. `bus_req` and `bus_cmd` stay steady until `bus_ack`.
- R3: A write miss issues a bus read. If `bus_shared` was low, the line becomes modified with the written word and the request completes. If it was high, an update (`bus_cmd` 1) carrying the written word follows.
- R4: A write hit on a clean-private or modified line completes in the same cycle with no bus transaction and leaves the line modified.
- R5: A write hit on a clean-shared line issues an update carrying the new word. Afterwards the line is clean-shared if `bus_shared` was high in the acknowledge cycle, and clean-private if it was low.
- R6: A read hit completes in the same cycle with the stored word and does not change the line state.
- R7: `snp_hit` is high in the cycle of a snooped read (`snp_cmd` 0) or update (`snp_cmd` 1) whose address matches a non-empty line, and low otherwise. A snooped write-back (`snp_cmd` 2) is ignored.
- R8: A snooped read or update that hits a modified line raises `snp_flush` with the line's old word on `snp_flush_data`. The line becomes clean-shared.
- R9: A snooped read or update that hits a clean line leaves it clean-shared. A snooped update also replaces the stored word with `snp_data`.
- R10: A miss whose victim is modified first issues a write-back (`bus_cmd` 2) of the victim's address and word, then the read. A clean victim is dropped with no bus transaction.
- R11: When a snooped read or update has the same index as an idle-state processor request, `cpu_rdy` is low in that cycle. The snoop takes effect first, and the request is served afterwards against the updated line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_rdy | output | 1 | Request completes at this edge |
| cpu_rdata | output | DW | Read data, valid with `cpu_rdy` |
| bus_req | output | 1 | Bus transaction pending |
| bus_cmd | output | 2 | 0 read, 1 update, 2 write-back |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Data for update and write-back |
| bus_ack | input | 1 | Transaction completes this cycle |
| bus_rdata | input | DW | Read data from the bus |
| bus_shared | input | 1 | Wired-OR sharing line, sampled with `bus_ack` |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | AW | Snooped address |
| snp_data | input | DW | Snooped update data |
| snp_hit | output | 1 | Drive onto the sharing line |
| snp_flush | output | 1 | Modified data supplied to memory |
| snp_flush_data | output | DW | Supplied word |

## Verification
The bench builds the cache with its defaults: 8-bit addresses, 16-bit words and four lines. Stimulus addresses use only three tag values. Repeated hits, clean and modified evictions, and snoops that hit or just miss a held line therefore all occur often. Bus acknowledge delays and the sampled sharing level are drawn at random, which covers both outcomes of every sharing-dependent transition. Directed steps cover the same-index snoop collision and the write-back-before-fill order.

// File: rtl/wupd_cache.sv
module wupd_cache #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_rdy,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_shared,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_data,
  output logic          snp_hit,
  output logic          snp_flush,
  output logic [DW-1:0] snp_flush_data
);
  localparam int TW = AW - IW;
  localparam int NL = 1 << IW;
  localparam logic [1:0] CMD_RD = 2'd0, CMD_UPD = 2'd1, CMD_WB = 2'd2;

  typedef enum logic [1:0] {L_INV, L_EXC, L_SHR, L_DRT} lst_t;
  typedef enum logic [1:0] {F_IDLE, F_WB, F_FILL, F_UPD} fsm_t;

  lst_t          lst  [NL];
  logic [TW-1:0] ltag [NL];
  logic [DW-1:0] ldat [NL];
  fsm_t          fsm;

  wire [IW-1:0] cidx = cpu_addr[IW-1:0];
  wire [TW-1:0] ctag = cpu_addr[AW-1:IW];
  wire [IW-1:0] sidx = snp_addr[IW-1:0];
  wire [TW-1:0] stag = snp_addr[AW-1:IW];

  wire snp_act = snp_valid && snp_cmd != CMD_WB;
  wire collide = snp_act && sidx == cidx;
  wire chit    = lst[cidx] != L_INV && ltag[cidx] == ctag;
  wire go      = fsm == F_IDLE && cpu_req && !collide;

  assign snp_hit        = snp_act && lst[sidx] != L_INV && ltag[sidx] == stag;
  assign snp_flush      = snp_hit && lst[sidx] == L_DRT;
  assign snp_flush_data = ldat[sidx];

  assign bus_req   = fsm != F_IDLE;
  assign bus_cmd   = fsm == F_WB ? CMD_WB : (fsm == F_UPD ? CMD_UPD : CMD_RD);
  assign bus_addr  = fsm == F_WB ? {ltag[cidx], cidx} : cpu_addr;
  assign bus_wdata = fsm == F_WB ? ldat[cidx] : cpu_wdata;
  assign cpu_rdata = fsm == F_FILL ? bus_rdata : ldat[cidx];

  always_comb begin
    case (fsm)
      F_IDLE:  cpu_rdy = go && chit && !(cpu_we && lst[cidx] == L_SHR);
      F_FILL:  cpu_rdy = bus_ack && !(cpu_we && bus_shared);
      F_UPD:   cpu_rdy = bus_ack;
      default: cpu_rdy = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm <= F_IDLE;
      for (int i = 0; i < NL; i++) begin
        lst[i]  <= L_INV;
        ltag[i] <= '0;
        ldat[i] <= '0;
      end
    end else begin
      if (snp_hit) begin
        lst[sidx] <= L_SHR;
        if (snp_cmd == CMD_UPD) ldat[sidx] <= snp_data;
      end
      case (fsm)
        F_IDLE:
          if (go) begin
            if (chit) begin
              if (cpu_we) begin
                if (lst[cidx] == L_SHR) fsm <= F_UPD;
                else begin
                  lst[cidx]  <= L_DRT;
                  ldat[cidx] <= cpu_wdata;
                end
              end
            end else begin
              fsm <= (lst[cidx] == L_DRT) ? F_WB : F_FILL;
            end
          end
        F_WB:
          if (bus_ack) begin
            lst[cidx] <= L_INV;
            fsm       <= F_FILL;
          end
        F_FILL:
          if (bus_ack) begin
            ltag[cidx] <= ctag;
            if (!cpu_we) begin
              lst[cidx]  <= bus_shared ? L_SHR : L_EXC;
              ldat[cidx] <= bus_rdata;
              fsm        <= F_IDLE;
            end else begin
              ldat[cidx] <= cpu_wdata;
              lst[cidx]  <= bus_shared ? L_SHR : L_DRT;
              fsm        <= bus_shared ? F_UPD : F_IDLE;
            end
          end
        F_UPD:
          if (bus_ack) begin
            lst[cidx]  <= bus_shared ? L_SHR : L_EXC;
            ldat[cidx] <= cpu_wdata;
            fsm        <= F_IDLE;
          end
        default: fsm <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wupd_cache_chk.sv
module wupd_cache_chk #(
  parameter int AW = 8,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_rdy,
  input logic [AW-1:0] cpu_addr,
  input logic          bus_req,
  input logic [1:0]    bus_cmd,
  input logic          bus_ack,
  input logic          snp_valid,
  input logic [1:0]    snp_cmd,
  input logic [AW-1:0] snp_addr,
  input logic          snp_hit,
  input logic          snp_flush
);
  AST_RDY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdy |-> cpu_req);  // R6
  AST_HIT_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hit |-> (snp_valid && snp_cmd != 2'd2));  // R7
  AST_FLUSH_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_hit);  // R8
  AST_WB_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == 2'd2 && bus_ack) |=> (bus_req && bus_cmd == 2'd0));  // R10
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_cmd)));  // R2
  AST_COLLIDE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd != 2'd2 && !bus_req &&
     snp_addr[IW-1:0] == cpu_addr[IW-1:0]) |-> !cpu_rdy);  // R11
endmodule

bind wupd_cache wupd_cache_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_rdy(cpu_rdy),
  .cpu_addr(cpu_addr), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_ack(bus_ack),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
  .snp_hit(snp_hit), .snp_flush(snp_flush)
);

// File: tb/test_wupd_cache.sv
`timescale 1ns/100ps
module test_wupd_cache;
  localparam int AW = 8, DW = 16, IW = 2, NL = 4, TW = AW - IW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cpu_req, cpu_we, cpu_rdy, bus_req, bus_ack, bus_shared;
  logic snp_valid, snp_hit, snp_flush;
  logic [AW-1:0] cpu_addr, bus_addr, snp_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, bus_wdata, bus_rdata, snp_data, snp_flush_data;
  logic [1:0] bus_cmd, snp_cmd;

  wupd_cache #(.AW(AW), .DW(DW), .IW(IW)) i_wupd_cache (.*);

  int n_chk = 0, n_fail = 0, force_sh = -1;
  int ref_st [NL];
  logic [TW-1:0] ref_tag [NL];
  logic [DW-1:0] ref_dat [NL];
  logic [DW-1:0] mem [256];

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic pick_sh();
    return force_sh < 0 ? logic'($urandom % 2) : logic'(force_sh);
  endfunction

  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int ix = int'(a[IW-1:0]);
    logic [TW-1:0] tg = a[AW-1:IW];
    logic [1:0] xc [3];
    logic [AW-1:0] xa [3];
    logic [DW-1:0] xd [3], xr [3], exp_rd;
    logic xs [3], sh, done;
    int n = 0, k = 0, cyc = 0;
    string rq;
    logic hit = ref_st[ix] != 0 && ref_tag[ix] == tg;
    exp_rd = '0;
    if (hit) begin
      if (!we) begin rq = "R6"; exp_rd = ref_dat[ix]; end
      else if (ref_st[ix] == 2) begin
        rq = "R5"; sh = pick_sh();
        xc[0] = 2'd1; xa[0] = a; xd[0] = d; xs[0] = sh; xr[0] = '0; n = 1;
        ref_st[ix] = sh ? 2 : 1; ref_dat[ix] = d; mem[a] = d;
      end else begin rq = "R4"; ref_st[ix] = 3; ref_dat[ix] = d; end
    end else begin
      rq = we ? "R3" : "R2";
      if (ref_st[ix] == 3) begin
        rq = "R10";
        xc[0] = 2'd2; xa[0] = {ref_tag[ix], a[IW-1:0]}; xd[0] = ref_dat[ix]; xs[0] = 1'b0; xr[0] = '0;
        mem[xa[0]] = ref_dat[ix]; n = 1;
      end
      sh = pick_sh();
      xc[n] = 2'd0; xa[n] = a; xd[n] = '0; xs[n] = sh; xr[n] = mem[a]; n++;
      ref_tag[ix] = tg;
      if (!we) begin ref_st[ix] = sh ? 2 : 1; ref_dat[ix] = mem[a]; exp_rd = mem[a]; end
      else if (!sh) begin ref_st[ix] = 3; ref_dat[ix] = d; end
      else begin
        sh = pick_sh();
        xc[n] = 2'd1; xa[n] = a; xd[n] = d; xs[n] = sh; xr[n] = '0; n++;
        ref_st[ix] = sh ? 2 : 1; ref_dat[ix] = d; mem[a] = d;
      end
    end
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    done = 1'b0;
    while (!done && cyc < 60) begin
      #0.5;
      if (bus_req && k >= n) begin
        chk(rq, "unexpected bus transaction", 32'(bus_cmd), 32'hF);
        done = 1'b1;
      end else if (bus_req) begin
        bus_ack = logic'($urandom % 2); bus_shared = xs[k]; bus_rdata = xr[k];
      end else bus_ack = 1'b0;
      #0.5;
      if (!done && bus_req && bus_ack) begin
        chk(rq, "bus_cmd", 32'(bus_cmd), 32'(xc[k]));
        chk(rq, "bus_addr", 32'(bus_addr), 32'(xa[k]));
        if (xc[k] != 2'd0) chk(rq, "bus_wdata", 32'(bus_wdata), 32'(xd[k]));
        k++;
      end
      if (!done && cpu_rdy) begin
        chk(rq, "transactions done at ready", 32'(k), 32'(n));
        if (n == 0) chk(rq, "hit completes in first cycle", 32'(cyc), 32'd0);
        if (!we) chk(rq, "cpu_rdata", 32'(cpu_rdata), 32'(exp_rd));
        done = 1'b1;
      end
      @(posedge clk); #0.5;
      cyc++;
      if (!done) @(negedge clk);
    end
    if (!done) chk(rq, "request never completed", 32'd0, 32'd1);
    cpu_req = 1'b0; bus_ack = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int ix = int'(a[IW-1:0]);
    logic hit = c != 2'd2 && ref_st[ix] != 0 && ref_tag[ix] == a[AW-1:IW];
    logic fl = hit && ref_st[ix] == 3;
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a; snp_data = d;
    #1;
    chk("R7", "snp_hit", 32'(snp_hit), 32'(hit));
    chk("R8", "snp_flush", 32'(snp_flush), 32'(fl));
    if (fl) chk("R8", "snp_flush_data", 32'(snp_flush_data), 32'(ref_dat[ix]));
    @(posedge clk); #0.5;
    snp_valid = 1'b0;
    if (fl) mem[a] = ref_dat[ix];
    if (hit) begin ref_st[ix] = 2; if (c == 2'd1) ref_dat[ix] = d; end
    if (c != 2'd0) mem[a] = d;
  endtask

  task automatic collide_then_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int ix = int'(a[IW-1:0]);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    snp_valid = 1'b1; snp_cmd = 2'd0; snp_addr = a;
    #1;
    chk("R11", "cpu_rdy during same-index snoop", 32'(cpu_rdy), 32'd0);
    chk("R11", "snp_hit during collision", 32'(snp_hit), 32'd1);
    @(posedge clk); #0.5;
    cpu_req = 1'b0; snp_valid = 1'b0;
    ref_st[ix] = 2;
    cpu_op(1'b1, a, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < 256; i++) mem[i] = DW'(i * 37 + 11);
    for (int i = 0; i < NL; i++) begin ref_st[i] = 0; ref_tag[i] = '0; ref_dat[i] = '0; end
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    bus_ack = 1'b0; bus_shared = 1'b0; bus_rdata = '0;
    snp_valid = 1'b0; snp_cmd = '0; snp_addr = '0; snp_data = '0;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "bus_req after reset", 32'(bus_req), 32'd0);
    chk("R1", "cpu_rdy after reset", 32'(cpu_rdy), 32'd0);
    snoop(2'd0, 8'h00, '0);
    snoop(2'd1, 8'h07, 16'h1234);

    force_sh = 0;
    cpu_op(1'b0, 8'h05, '0);          // R2 miss, private
    cpu_op(1'b1, 8'h05, 16'hA001);    // R4 silent write
    cpu_op(1'b1, 8'h05, 16'hA002);    // R4 stays modified
    snoop(2'd0, 8'h05, '0);           // R8 flush
    cpu_op(1'b1, 8'h05, 16'hA003);    // R5 update, back to private
    cpu_op(1'b1, 8'h05, 16'hA004);    // R4
    cpu_op(1'b0, 8'h05, '0);          // R6
    snoop(2'd2, 8'h05, 16'h5555);     // R7 write-back ignored
    snoop(2'd1, 8'h05, 16'hBEEF);     // R8 + R9
    cpu_op(1'b0, 8'h05, '0);          // R9 data visible
    cpu_op(1'b1, 8'h09, 16'hC001);    // R3 write miss, clean victim R10
    cpu_op(1'b0, 8'h0D, '0);          // R10 dirty victim
    force_sh = 1;
    cpu_op(1'b1, 8'h12, 16'hD001);    // R3 read then update
    cpu_op(1'b0, 8'h16, '0);          // R2 shared fill, clean evict
    force_sh = 0;
    collide_then_write(8'h0D, 16'hE001); // R11

    force_sh = -1;
    for (int t = 0; t < 500; t++) begin
      logic [AW-1:0] a = {TW'($urandom % 3), IW'($urandom)};
      int r = int'($urandom % 10);
      if (r < 3) cpu_op(1'b0, a, '0);
      else if (r < 6) cpu_op(1'b1, a, DW'($urandom));
      else if (r < 9) snoop(2'($urandom % 2), a, DW'($urandom));
      else snoop(2'd2, a, DW'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule